// File: doc/BRIEF.md
# Packed Indexed Pixel Unpacker

This block sits between a frame-buffer fetch path and a palette stage. It receives bytes that each hold one or more color-index pixels packed at 1, 2, 4 or 8 bits per pixel. It sends out one pixel index per handshake, in the order the pixels appear on screen. Both sides use a valid/ready handshake. Every index leaves the block zero-extended to a full byte.

A configuration input chooses which end of each byte holds the first on-screen pixel: the most significant field or the least significant one. This choice belongs to the display path alone. It changes only the order in which whole fields are sent out. The bits inside each field keep their significance in both orders. The pixel width and the order are captured together with each byte, so software may change them while a byte is still draining. At one byte per pixel the order setting does nothing.

Top module: `pix_unpack`

## Requirements
- R1: `cfg_width` selects the pixel width: code 0 is 1 bit (8 pixels per byte), code 1 is 2 bits (4 pixels), code 2 is 4 bits (2 pixels) and code 3 is 8 bits (1 pixel).
- R2: With `cfg_low_first` = 0, pixel j of a byte (field width W, counting from 0) is taken from bits [8-W*(j+1) +: W], so the first pixel comes from the top field.
- R3: With `cfg_low_first` = 1, pixel j of a byte is taken from bits [W*j +: W], so the first pixel comes from the bottom field.
- R4: Bits inside a field are never reversed. `out_idx` carries the field in bits [W-1:0], and all of its upper bits are zero.
- R5: Bytes are used strictly in the order they arrive. Byte k supplies output pixels k*N to k*N+N-1, and exactly one pixel leaves per cycle with `out_valid` and `out_ready` both high.
- R6: While a byte is held, `in_ready` is high only in a cycle where the last pixel of that byte is being accepted. When nothing is held, `in_ready` is high.
- R7: With input always valid and output always ready, the output runs at one pixel per cycle with no idle cycle between bytes. The first pixel appears one cycle after the first byte is accepted.
- R8: Width and order are sampled when a byte is accepted. A change while that byte drains applies only from the next byte.
- R9: At 8 bits per pixel, `out_idx` equals the input byte whatever the value of `cfg_low_first`.
- R10: A synchronous reset drops the held byte and the pixel count. In the cycle after reset, `out_valid` is low and `in_ready` is high.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_idx` stays the same in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_width | input | 2 | Pixel width code, sampled with each byte |
| cfg_low_first | input | 1 | 1: first pixel from the low field; 0: from the high field |
| in_data | input | 8 | Packed pixel byte |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept a byte |
| out_idx | output | 8 | Zero-extended pixel index |
| out_valid | output | 1 | Output index valid |
| out_ready | input | 1 | Consumer accepts the index |

## Verification
If the slot counter is wrong, pixels come out in the wrong field order, or a byte drains with too many or too few pixels. Field order shows in the first output pixel after a load. A wrong pixel count shows as early or late `in_ready` within one byte's drain. If a wrong width or order is latched, a mid-drain configuration change shows up on the very next pixel. A lost hold or a bubble shows in the cycle after a stall or at the boundary between two bytes.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;
   // Width selector: field width is 1 << code
   typedef enum logic [1:0] {
      PW_1 = 2'd0,
      PW_2 = 2'd1,
      PW_4 = 2'd2,
      PW_8 = 2'd3
   } pix_width_e;

   function automatic int unsigned pix_per_word(input int unsigned word_w, input int unsigned code);
      return word_w >> code;
   endfunction
endpackage

// File: rtl/pix_field_sel.sv
module pix_field_sel #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned IDX_W  = 8,
   localparam int unsigned SLOT_W  = $clog2(BYTE_W),
   localparam int unsigned NUM_W   = SLOT_W + 1,
   localparam int unsigned WCODE_W = $clog2(NUM_W)
) (
   input  logic [BYTE_W-1:0]  word_i,
   input  logic [WCODE_W-1:0] width_i,
   input  logic               low_first_i,
   input  logic [SLOT_W-1:0]  slot_i,
   output logic [IDX_W-1:0]   idx_o
);
   logic [BYTE_W-1:0] cand [NUM_W];

   for (genvar g = 0; g < NUM_W; g++) begin : g_width
      localparam int unsigned FW = 1 << g;
      localparam int unsigned NP = BYTE_W / FW;
      localparam logic [BYTE_W-1:0] FMASK = BYTE_W'((64'd1 << FW) - 64'd1);
      logic [SLOT_W-1:0] pos;
      // Field position: count up from the bottom or down from the top
      assign pos = low_first_i ? slot_i : (SLOT_W'(NP - 1) - slot_i);
      assign cand[g] = (word_i >> (32'(pos) * FW)) & FMASK;
   end

   assign idx_o = IDX_W'(cand[width_i]);
endmodule

// File: rtl/pix_slot_ctr.sv
module pix_slot_ctr #(
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned SLOT_W  = $clog2(BYTE_W),
   localparam int unsigned WCODE_W = $clog2(SLOT_W + 1)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               load_i,
   input  logic               step_i,
   input  logic [WCODE_W-1:0] width_i,
   output logic [SLOT_W-1:0]  slot_o,
   output logic               last_o
);
   logic [SLOT_W-1:0] slot_q;

   always_ff @(posedge clk) begin
      if (rst)         slot_q <= '0;
      else if (load_i) slot_q <= '0;
      else if (step_i) slot_q <= slot_q + 1'b1;
   end

   assign slot_o = slot_q;
   assign last_o = (slot_q == SLOT_W'(pix_unpack_pkg::pix_per_word(BYTE_W, 32'(width_i)) - 1));
endmodule

// File: rtl/pix_unpack.sv
module pix_unpack #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned IDX_W  = 8,
   localparam int unsigned SLOT_W  = $clog2(BYTE_W),
   localparam int unsigned WCODE_W = $clog2(SLOT_W + 1)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [WCODE_W-1:0] cfg_width,
   input  logic               cfg_low_first,
   input  logic [BYTE_W-1:0]  in_data,
   input  logic               in_valid,
   output logic               in_ready,
   output logic [IDX_W-1:0]   out_idx,
   output logic               out_valid,
   input  logic               out_ready
);
   if (BYTE_W != (1 << SLOT_W) || BYTE_W < 2) begin : g_bad_byte
      $error("pix_unpack: BYTE_W must be a power of two, at least 2");
   end
   if (IDX_W < BYTE_W) begin : g_bad_idx
      $error("pix_unpack: IDX_W must be at least BYTE_W");
   end

   logic                full_q;
   logic [BYTE_W-1:0]   word_q;
   logic [WCODE_W-1:0]  width_q;
   logic                lowf_q;
   logic [SLOT_W-1:0]   slot;
   logic                last;
   logic                fire, drain, load;

   assign fire     = full_q & out_ready;
   assign drain    = fire & last;
   assign in_ready = ~full_q | drain;
   assign load     = in_valid & in_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         full_q  <= 1'b0;
         word_q  <= '0;
         width_q <= '0;
         lowf_q  <= 1'b0;
      end else if (load) begin
         full_q  <= 1'b1;
         word_q  <= in_data;
         width_q <= cfg_width;
         lowf_q  <= cfg_low_first;
      end else if (drain) begin
         full_q  <= 1'b0;
      end
   end

   pix_slot_ctr #(.BYTE_W(BYTE_W)) u_ctr (
      .clk     (clk),
      .rst     (rst),
      .load_i  (load),
      .step_i  (fire & ~last),
      .width_i (width_q),
      .slot_o  (slot),
      .last_o  (last)
   );

   pix_field_sel #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_sel (
      .word_i      (word_q),
      .width_i     (width_q),
      .low_first_i (lowf_q),
      .slot_i      (slot),
      .idx_o       (out_idx)
   );

   assign out_valid = full_q;
endmodule

// File: rtl/pix_unpack_chk.sv
module pix_unpack_chk #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned IDX_W  = 8,
   localparam int unsigned SLOT_W  = $clog2(BYTE_W),
   localparam int unsigned WCODE_W = $clog2(SLOT_W + 1),
   localparam int unsigned CNT_W   = SLOT_W + 2
) (
   input logic               clk,
   input logic               rst,
   input logic [WCODE_W-1:0] cfg_width,
   input logic               cfg_low_first,
   input logic [BYTE_W-1:0]  in_data,
   input logic               in_valid,
   input logic               in_ready,
   input logic [IDX_W-1:0]   out_idx,
   input logic               out_valid,
   input logic               out_ready
);
   logic             held;
   logic [CNT_W-1:0] fires;
   logic [CNT_W-1:0] npix;
   logic [CNT_W-1:0] fwid;
   logic             rst_d;
   logic             acc, ofire;

   assign acc   = in_valid & in_ready;
   assign ofire = out_valid & out_ready;

   always_ff @(posedge clk) begin
      rst_d <= rst;
      if (rst) begin
         held  <= 1'b0;
         fires <= '0;
         npix  <= CNT_W'(1);
         fwid  <= CNT_W'(BYTE_W);
      end else if (acc) begin
         held  <= 1'b1;
         fires <= '0;
         npix  <= CNT_W'(BYTE_W >> cfg_width);
         fwid  <= CNT_W'(1 << cfg_width);
      end else if (ofire) begin
         fires <= fires + 1'b1;
      end
   end

   AST_DRAIN_COUNT: assert property (@(posedge clk) disable iff (rst)
      (acc && held) |-> ((fires + CNT_W'(ofire)) == npix)); // R5

   AST_NO_EXTRA: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (fires < npix)); // R6

   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> ((32'(out_idx) >> fwid) == 0)); // R4

   AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (rst)
      (ofire && (fires == npix - 1'b1) && in_valid) |=> out_valid); // R7

   AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_idx))); // R11

   always @(negedge clk) begin
      if (rst_d === 1'b1 && rst === 1'b0)
         AST_RESET_IDLE: assert (!out_valid && in_ready); // R10
   end
endmodule

bind pix_unpack pix_unpack_chk #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_chk (
   .clk           (clk),
   .rst           (rst),
   .cfg_width     (cfg_width),
   .cfg_low_first (cfg_low_first),
   .in_data       (in_data),
   .in_valid      (in_valid),
   .in_ready      (in_ready),
   .out_idx       (out_idx),
   .out_valid     (out_valid),
   .out_ready     (out_ready)
);

// File: tb/pix_unpack_test.sv
`timescale 1ns/1ps
module pix_unpack_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] cfg_width = 2'd0;
   logic       cfg_low_first = 1'b0;
   logic [7:0] in_data = 8'd0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [7:0] out_idx;
   logic       out_valid;
   logic       out_ready = 1'b0;

   int n_total = 0;
   int n_bad   = 0;
   bit done    = 1'b0;

   logic [7:0] bq  [32];
   int         bw  [32];
   int         blf [32];

   always #2 clk = ~clk;

   pix_unpack uut (
      .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_low_first(cfg_low_first),
      .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
      .out_idx(out_idx), .out_valid(out_valid), .out_ready(out_ready)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_total++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   // Model from R1-style width codes and R2/R3 field placement
   function automatic int model_pix(input logic [7:0] b, input int w, input int lf, input int j);
      int fw = 1 << w;
      int np = 8 >> w;
      int p  = lf ? j : (np - 1 - j);
      return (int'(b) >> (p * fw)) & ((1 << fw) - 1);
   endfunction

   task automatic run_stream(input int nb, input int rdy_mode, input int vld_mode, input string tag);
      int exp_v [256];
      bit exp_l [256];
      int total = 0;
      int sent = 0, got = 0, cyc = 0, bubbles = 0;
      bit pv = 0, pr = 0;
      int pidx = 0;
      for (int k = 0; k < nb; k++) begin
         for (int j = 0; j < (8 >> bw[k]); j++) begin
            exp_v[total] = model_pix(bq[k], bw[k], blf[k], j);
            exp_l[total] = (j == (8 >> bw[k]) - 1);
            total++;
         end
      end
      while (got < total && cyc < 4000) begin
         @(negedge clk);
         in_valid = (sent < nb) && (vld_mode == 0 || (cyc % 2) == 0);
         if (sent < nb) begin
            in_data       = bq[sent];
            cfg_width     = 2'(bw[sent]);
            cfg_low_first = blf[sent][0];
         end
         out_ready = (rdy_mode == 0) || ((cyc % 3) != 0);
         #1;
         if (got > 0 && !out_valid) bubbles++;
         if (pv && !pr)
            chk(out_valid && out_idx == 8'(pidx), {tag, " R11 hold"}, int'(out_idx), pidx);
         if (out_valid)
            chk(in_ready == (out_ready && exp_l[got]), {tag, " R6 in_ready"}, int'(in_ready),
                int'(out_ready && exp_l[got]));
         if (out_valid && out_ready) begin
            chk(out_idx == 8'(exp_v[got]), {tag, " R5 pixel"}, int'(out_idx), exp_v[got]);
            got++;
         end
         if (in_valid && in_ready) sent++;
         pv = out_valid; pr = out_ready; pidx = int'(out_idx);
         cyc++;
      end
      @(negedge clk);
      in_valid = 1'b0;
      chk(got == total, {tag, " R5 count"}, got, total);
      if (rdy_mode == 0 && vld_mode == 0) begin
         chk(bubbles == 0, {tag, " R7 bubbles"}, bubbles, 0);
         chk(cyc == total + 1, {tag, " R7 cycles"}, cyc, total + 1);
      end
   endtask

   task automatic t_reset();
      @(negedge clk); #1;
      chk(out_valid == 1'b0, "R10 reset out_valid", int'(out_valid), 0);
      chk(in_ready == 1'b1, "R10 reset in_ready", int'(in_ready), 1);
   endtask

   task automatic t_widths();
      for (int w = 0; w < 4; w++) begin
         for (int lf = 0; lf < 2; lf++) begin
            bq[0] = 8'hB4; bq[1] = 8'h1E; bq[2] = 8'hC9;
            for (int k = 0; k < 3; k++) begin bw[k] = w; blf[k] = lf; end
            run_stream(3, 0, 0, $sformatf("R1 R2 R3 R4 w=%0d lf=%0d", w, lf));
         end
      end
   endtask

   task automatic t_backpressure();
      bq[0] = 8'h6C; bq[1] = 8'hF0; bq[2] = 8'h35; bq[3] = 8'h81;
      for (int k = 0; k < 4; k++) begin bw[k] = 1; blf[k] = k % 2; end
      run_stream(4, 1, 1, "R11 R6 stall");
   endtask

   task automatic t_cfg_change();
      bq[0] = 8'h9A; bw[0] = 2; blf[0] = 0;
      bq[1] = 8'h47; bw[1] = 0; blf[1] = 1;
      bq[2] = 8'hE2; bw[2] = 1; blf[2] = 0;
      bq[3] = 8'h5D; bw[3] = 3; blf[3] = 1;
      bq[4] = 8'h2B; bw[4] = 2; blf[4] = 1;
      run_stream(5, 0, 0, "R8 cfg change");
   endtask

   task automatic t_8bpp_order();
      for (int k = 0; k < 6; k++) begin bq[k] = 8'(8'h13 * (k + 3)); bw[k] = 3; blf[k] = k % 2; end
      run_stream(6, 0, 0, "R9 8bpp");
      for (int k = 0; k < 6; k++)
         chk(model_pix(bq[k], 3, 1, 0) == int'(bq[k]), "R9 order ignored", model_pix(bq[k], 3, 1, 0), int'(bq[k]));
   endtask

   task automatic t_mid_reset();
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'hA5; cfg_width = 2'd0; cfg_low_first = 1'b0; out_ready = 1'b0;
      @(negedge clk);
      in_valid = 1'b0; out_ready = 1'b1;
      #1;
      chk(out_idx == 8'd1, "R2 first bit7", int'(out_idx), 1);
      @(negedge clk); #1;
      chk(out_idx == 8'd0, "R2 second bit6", int'(out_idx), 0);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk(out_valid == 1'b0, "R10 mid reset out_valid", int'(out_valid), 0);
      chk(in_ready == 1'b1, "R10 mid reset in_ready", int'(in_ready), 1);
      bq[0] = 8'h3C; bw[0] = 2; blf[0] = 1;
      run_stream(1, 0, 0, "R10 after reset");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_widths();
      t_backpressure();
      t_cfg_change();
      t_8bpp_order();
      t_mid_reset();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", n_total, n_bad);
         $finish;
      end
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         done = 1'b1;
         chk(1'b0, "watchdog", 0, 1);
         $display("test done: total=%0d bad=%0d", n_total, n_bad);
         $finish;
      end
   end
endmodule